// File: doc/BRIEF.md
# Lockable Configuration Byte File

A 256-entry, byte-wide configuration store. A serial slave engine outside the block reaches it through a plain port: an address, write data, a write strobe and a read strobe. Read data appears one clock after the read strobe. Locations 00h to FEh hold configuration bytes, and each byte has a power-on value computed from parameters. The top location, FFh, is a command byte whose low three bits have side effects.

Setting the attach bit raises the attach request output and locks the lower 255 locations against writes. Setting the reset bit reloads every location with its power-on value one cycle later, and that reload also drops the lock. Setting the power-down bit arms a request. The request is latched only when the slave engine pulses its acknowledge-done input, so the interface is powered down only after the acknowledge in flight has finished. The latched request then stays set until the hardware reset.

Top module: `cfg_lockfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, every location n in 00h..FEh holds ((n*37) mod 256) XOR 5Ah with the default parameters. Location FFh reads 00h, and `attach_req` and `pwrdn_req` are 0.
- R2: A cycle with `rd_en`=1 captures the byte at `addr`. That byte appears on `rdata` from the next cycle, and `rdata` holds it until the next read.
- R3: While unlocked, a cycle with `wr_en`=1 and `addr` in 00h..FEh stores `wdata` at that location.
- R4: Writing FFh with bit 0 = 1 sets `attach_req` from the next cycle. While it is set, writes to 00h..FEh leave the stored bytes unchanged, but reads still return them. FFh stays writable, and writing bit 0 = 0 removes the lock.
- R5: At FFh, bits 7:3 always read 0 and ignore written values. Bits 0, 1 and 2 read back as the attach, reset and power-down bits.
- R6: Writing FFh with bit 1 = 1 causes one reset cycle. In that cycle, every location 00h..FEh is reloaded with its R1 value and FFh is cleared, which clears the attach bit, the lock and bit 1 itself. Any write presented during the reset cycle is dropped.
- R7: An `ack_done` pulse in a cycle where FFh bit 2 already reads 1 sets `pwrdn_req` from the next cycle. An `ack_done` pulse while bit 2 is 0 has no effect.
- R8: Once set, `pwrdn_req` stays at 1. It stays set through a soft reset and through clearing bit 2, and only `rst_n` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Location selected for a read or a write |
| wdata | input | 8 | Byte to write |
| ack_done | input | 1 | Pulse from the slave engine when an acknowledge has completed |
| rdata | output | 8 | Byte captured by the last read |
| attach_req | output | 1 | Attach request; also the write lock for 00h..FEh |
| pwrdn_req | output | 1 | Latched request to power down the slave interface |

## Verification
The bench goes after the following corner cases:
- **Write presented during the soft-reset cycle.** A design that let it through would show the written byte instead of the default.
- **Command write that sets attach and reset together.** A design that did not let the reset win would stay locked after the reload.
- **Writes while locked.** A design that did not gate them would return the new data on a later read.
- **Lock removal.** A design that kept the lock after bit 0 was cleared would refuse writes it should store.
- **Power-down arming order.** An acknowledge pulse before bit 2 is set must not latch the request, and the request must survive both a soft reset and the clearing of bit 2. A design that got this wrong would either raise the request early or lose it.
- **Full-file default check.** Every location is read back after hardware reset and after a soft reset. This catches a default value off by one location, or a reload that misses part of the file.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  // Positions of the live bits in the command byte
  localparam int unsigned CMD_ATTACH = 0;
  localparam int unsigned CMD_SRST   = 1;
  localparam int unsigned CMD_PWRDN  = 2;
  localparam int unsigned CMD_LIVE_W = 3;

  typedef struct packed {
    logic pwrdn;
    logic srst;
    logic attach;
  } cmd_bits_t;

  // Power-on value of one location, before truncation to the data width
  function automatic int unsigned default_value(int unsigned idx,
                                                int unsigned mult,
                                                int unsigned seed);
    return (idx * mult) ^ seed;
  endfunction

  // Take the live command bits out of a written byte
  function automatic cmd_bits_t cmd_decode(logic [CMD_LIVE_W-1:0] low);
    cmd_bits_t c;
    c.attach = low[CMD_ATTACH];
    c.srst   = low[CMD_SRST];
    c.pwrdn  = low[CMD_PWRDN];
    return c;
  endfunction

  // Put the live command bits back at their positions for a read
  function automatic logic [CMD_LIVE_W-1:0] cmd_encode(cmd_bits_t c);
    logic [CMD_LIVE_W-1:0] v;
    v = '0;
    v[CMD_ATTACH] = c.attach;
    v[CMD_SRST]   = c.srst;
    v[CMD_PWRDN]  = c.pwrdn;
    return v;
  endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEF_MULT = 37,
  parameter int unsigned DEF_SEED = 32'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  import cfg_lock_pkg::*;

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LAST  = DEPTH - 1;

  logic [DATA_W-1:0] cells [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < LAST; gi++) begin : g_cell
      localparam logic [DATA_W-1:0] DEF =
        DATA_W'(default_value(gi, DEF_MULT, DEF_SEED));
      logic hit;
      assign hit = we && (waddr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cells[gi] <= DEF;
        else if (soft_rst) cells[gi] <= DEF;
        else if (hit)      cells[gi] <= wdata;
      end
    end
    // The top slot is the command byte and lives elsewhere
    assign cells[LAST] = '0;
  endgenerate

  assign rdata = cells[raddr];

endmodule

// File: rtl/cfg_cmd.sv
module cfg_cmd #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_done,
  output logic              attach,
  output logic              srst,
  output logic              pwrdn_bit,
  output logic              pwrdn_req,
  output logic [DATA_W-1:0] cmd_byte
);
  import cfg_lock_pkg::*;

  cmd_bits_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (cur.srst)  nxt = '0;
    else if (we)   nxt = cmd_decode(wdata[CMD_LIVE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // Armed request latches only once the acknowledge has completed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pwrdn_req <= 1'b0;
    else if (ack_done && cur.pwrdn) pwrdn_req <= 1'b1;
  end

  assign attach    = cur.attach;
  assign srst      = cur.srst;
  assign pwrdn_bit = cur.pwrdn;
  assign cmd_byte  = {{(DATA_W-CMD_LIVE_W){1'b0}}, cmd_encode(cur)};

endmodule

// File: rtl/cfg_rdport.sv
module cfg_rdport #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sel_cmd,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_cmd ? cmd_data : mem_data;
  end
endmodule

// File: rtl/cfg_lockfile.sv
module cfg_lockfile #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DEF_MULT = 37,
  parameter int unsigned DEF_SEED = 32'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_done,
  output logic [DATA_W-1:0] rdata,
  output logic              attach_req,
  output logic              pwrdn_req
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = '1;

  // Named internal events, brought out for the checker
  logic              is_cmd;
  logic              soft_rst;
  logic              cmd_we;
  logic              mem_we;
  logic              wr_blocked;
  logic              pwrdn_bit;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] cmd_byte;

  assign is_cmd     = (addr == CMD_ADDR);
  assign cmd_we     = wr_en && is_cmd && !soft_rst;
  assign wr_blocked = wr_en && !is_cmd && attach_req;
  assign mem_we     = wr_en && !is_cmd && !attach_req && !soft_rst;

  cfg_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_MULT(DEF_MULT), .DEF_SEED(DEF_SEED)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .we(mem_we),
    .waddr(addr), .wdata(wdata), .raddr(addr), .rdata(mem_rdata)
  );

  cfg_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .wdata(wdata),
    .ack_done(ack_done), .attach(attach_req), .srst(soft_rst),
    .pwrdn_bit(pwrdn_bit), .pwrdn_req(pwrdn_req), .cmd_byte(cmd_byte)
  );

  cfg_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel_cmd(is_cmd),
    .mem_data(mem_rdata), .cmd_data(cmd_byte), .rdata(rdata)
  );

endmodule

// File: rtl/cfg_lockfile_chk.sv
module cfg_lockfile_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ack_done,
  input logic [DATA_W-1:0] rdata,
  input logic              attach_req,
  input logic              pwrdn_req,
  input logic              mem_we,
  input logic              soft_rst,
  input logic              pwrdn_bit
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  // R4: a locked lower write never reaches the store
  a_r4_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != TOP && attach_req) |-> !mem_we);

  // R4: attach only rises after a command write with bit 0 set
  a_r4_attach_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attach_req) |-> $past(wr_en && addr == TOP && wdata[0]));

  // R6: the reset cycle clears the lock and ends itself
  a_r6_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!attach_req && !soft_rst));

  // R7: the request rises only after an acknowledge while armed
  a_r7_pwrdn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrdn_req) |-> $past(ack_done && pwrdn_bit));

  // R8: the request never drops without hardware reset
  a_r8_pwrdn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_req |=> pwrdn_req);

  // R5: reserved command bits read back as zero
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == TOP) |-> (rdata[DATA_W-1:3] == '0));

endmodule

bind cfg_lockfile cfg_lockfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .ack_done(ack_done), .rdata(rdata), .attach_req(attach_req),
  .pwrdn_req(pwrdn_req), .mem_we(mem_we), .soft_rst(soft_rst),
  .pwrdn_bit(pwrdn_bit)
);

// File: tb/tb_cfg_lockfile.sv
`timescale 1ns/1ps
module tb_cfg_lockfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ack_done = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       attach_req, pwrdn_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model
  logic [7:0] ref_mem [256];
  logic       m_att, m_pd, m_pdreq;

  always #5 clk = ~clk;

  cfg_lockfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ack_done(ack_done), .rdata(rdata),
    .attach_req(attach_req), .pwrdn_req(pwrdn_req)
  );

  // Power-on value restated as shifts and adds: 37n = 32n + 4n + n
  function automatic logic [7:0] exp_default(int n);
    int s;
    s = (n << 5) + (n << 2) + n;
    return 8'(s) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    if (a == 255) return {5'b0, m_pd, 1'b0, m_att};
    return ref_mem[a];
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 255; i++) ref_mem[i] = exp_default(i);
    ref_mem[255] = 8'h00;
    m_att = 1'b0;
    m_pd  = 1'b0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_defaults();
    m_pdreq = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One-cycle write; no idle cycle afterwards
  task automatic write_raw(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    if (a == 8'hFF) begin
      m_att = d[0];
      m_pd  = d[2];
    end else if (!m_att) begin
      ref_mem[a] = d;
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    write_raw(a, d);
    model_write(a, d);
    if (a == 8'hFF && d[1]) begin
      @(negedge clk);          // the reset cycle
      model_defaults();
    end
  endtask

  task automatic do_read(logic [7:0] a, string req);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp_read(a));
  endtask

  task automatic pulse_ack();
    ack_done = 1'b1;
    @(negedge clk);
    ack_done = 1'b0;
    if (m_pd) m_pdreq = 1'b1;
  endtask

  task automatic check_outs(string req);
    check({req, " attach"}, {7'b0, attach_req}, {7'b0, m_att});
    check({req, " pwrdn"},  {7'b0, pwrdn_req},  {7'b0, m_pdreq});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h00C0FFEE));
    model_defaults();
    m_pdreq = 1'b0;

    // R1: state held while reset is asserted
    repeat (2) @(negedge clk);
    check("R1 rdata in reset", rdata, 8'h00);
    check_outs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R5: every location after hardware reset
    for (int i = 0; i < 256; i++) do_read(8'(i), "R1 default");

    // R2: rdata holds between reads
    do_read(8'h10, "R2 read");
    held = rdata;
    addr = 8'h20;
    repeat (3) @(negedge clk);
    check("R2 hold", rdata, held);

    // R3: plain writes
    do_write(8'h00, 8'hA1); do_read(8'h00, "R3 low edge");
    do_write(8'hFE, 8'hB2); do_read(8'hFE, "R3 high edge");

    // R5: reserved bits written as ones read 0
    do_write(8'hFF, 8'hF8); do_read(8'hFF, "R5 reserved");

    // R4: lock, dropped writes, reads still work, unlock
    do_write(8'hFF, 8'h01);
    check_outs("R4 attach set");
    do_write(8'h00, 8'h33); do_read(8'h00, "R4 locked low");
    do_write(8'hFE, 8'h44); do_read(8'hFE, "R4 locked high");
    do_read(8'hFF, "R4 cmd readback");
    do_write(8'hFF, 8'h00);
    check_outs("R4 attach clear");
    do_write(8'h00, 8'h55); do_read(8'h00, "R4 unlocked write");

    // R7: acknowledge before arming does nothing
    pulse_ack();
    check_outs("R7 ack unarmed");
    do_write(8'hFF, 8'h04);
    check_outs("R7 armed no ack");
    pulse_ack();
    check_outs("R7 ack armed");

    // R8: survives clearing bit 2
    do_write(8'hFF, 8'h00);
    check_outs("R8 after clear");

    // R6: attach and reset together, reset wins
    do_write(8'h05, 8'h99);
    do_write(8'hFF, 8'h03);
    check_outs("R6 R8 after soft reset");
    do_read(8'hFF, "R6 cmd cleared");
    do_write(8'h05, 8'h77); do_read(8'h05, "R6 unlocked after reset");

    // R6: write presented during the reset cycle is dropped
    write_raw(8'hFF, 8'h02);
    write_raw(8'h07, 8'hEE);   // lands in the reset cycle
    model_defaults();
    do_read(8'h07, "R6 write in reset cycle");
    for (int i = 0; i < 256; i++) do_read(8'(i), "R6 full reload");

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] a, d;
      op = int'($urandom % 8);
      a  = 8'($urandom);
      d  = 8'($urandom);
      case (op)
        0, 1, 2: do_write(a, d);
        3, 4, 5: do_read(a, "R2 R3 R4 random read");
        6: begin
          if ($urandom % 4 != 0) d[1] = 1'b0;
          do_write(8'hFF, d);
        end
        default: pulse_ack();
      endcase
      check_outs("R4 R7 R8 random");
    end

    // R8: only hardware reset clears the request
    hw_reset();
    check_outs("R8 R1 after hw reset");
    do_read(8'h00, "R1 after hw reset");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule